// File: doc/BRIEF.md
# Linked-Block Peripheral DMA Channel

This block is one DMA channel that takes its work from a chain of control blocks held in memory. Software puts the byte address of the first block in the block-pointer register and sets the run bit. The channel then reads the block and copies 32-bit words from a source address to a destination address until the byte count is used up. It then follows the block's link word to the next block. A link of zero ends the chain and the channel stops.

Either side of a copy can be paced by one of several peripheral request lines, which the block itself selects. A finished block can raise an interrupt. Software can pause the channel, abort the current block and move on to the next, or reset the whole channel. Memory is reached through a single word-wide request/acknowledge port with an error flag on the response. Software can read the live source and destination pointers while a copy runs.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset, the status word (offset 0x00) reads 0x0000_0010, meaning idle with the paused flag set. The block pointer (0x04), live source (0x0C), live destination (0x10) and link (0x1C) all read 0. `irq` and `mem_req` are low.
- R2: Writing a block address to 0x04 and then 1 to status bit 0 makes the channel read the control block at that address. The block holds eight words: a flags word, the source, the destination, the byte count, a stride word (ignored), the link, and two padding words. The channel then copies count/4 words from source to destination. A block with a count of 0 completes without moving any data.
- R3: After each word, the byte count drops by 4. The source advances by 4 when flags bit 8 is set, and the destination advances by 4 when flags bit 4 is set. A side whose increment bit is clear keeps the same address.
- R4: When a block completes, the block pointer takes the link value. If the link is 0, status bit 0 clears. Otherwise the next block is fetched and run.
- R5: A block that completes with flags bit 0 set raises status bit 2 and `irq`. Writing status with bit 2 set clears both.
- R6: Flags bit 10 paces source reads and flags bit 6 paces destination writes. The pacing line is `dreq[flags[16+:PSEL_W]]`. A paced word waits until that line is high. While the channel waits, status bit 5 reads 1, and high levels on other lines have no effect.
- R7: Writing 0 to status bit 0 pauses the channel. A memory access already in flight completes, no new request is issued, and status bit 4 reads 1. Writing 1 again resumes the copy where it stopped.
- R8: Writing status with bits 30 and 0 both set ends the current block without any further word moves and without an interrupt. The channel then goes on to the block's link.
- R9: An error response on any memory access sets status bit 8, clears bit 0, and stops the channel. No further requests are issued, and the failed word is not counted as written.
- R10: Writing status with bit 31 set returns every register and the sequencer to their reset values at that clock edge. It also drops any pending memory request.
- R11: Writes to the live source, live destination and link registers are ignored. A raised memory request holds its address and direction until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| dreq | input | NUM_DREQ | Peripheral request lines |
| irq | output | 1 | Block-complete interrupt |

## Verification
The bench targets several corner cases:
- A zero-length block. A design that copied one word anyway would corrupt the destination.
- A fixed destination. A design that advanced it anyway would spread the data over memory.
- Pacing on a line other than the one selected. A design that decoded the select field wrongly would run ahead.
- A pause in the middle of a copy. A design that kept issuing requests would show `mem_req` activity and a moving source pointer.
- An abort of a stalled block in a two-block chain. A design that got this wrong would either hang, write the aborted block's data, or raise its interrupt.
- An error on the second read. A design that ignored the error would keep writing.
- A soft reset in the middle of a block, which must leave every register at zero.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  // Status word bit positions
  localparam int CS_ACTIVE = 0;
  localparam int CS_INT    = 2;
  localparam int CS_PAUSED = 4;
  localparam int CS_HELD   = 5;
  localparam int CS_ERR    = 8;
  localparam int CS_ABORT  = 30;
  localparam int CS_RESET  = 31;

  // Control-block flags word bit positions
  localparam int TI_INTEN = 0;
  localparam int TI_DINC  = 4;
  localparam int TI_DPACE = 6;
  localparam int TI_SINC  = 8;
  localparam int TI_SPACE = 10;
  localparam int TI_PSEL  = 16;

  // Register window offsets
  localparam logic [4:0] OFF_CS  = 5'h00;
  localparam logic [4:0] OFF_CBA = 5'h04;
  localparam logic [4:0] OFF_SRC = 5'h0C;
  localparam logic [4:0] OFF_DST = 5'h10;
  localparam logic [4:0] OFF_NXT = 5'h1C;

  // Control-block word indices that are fetched (padding is never read)
  localparam int          FIDX_W = 3;
  localparam logic [2:0]  W_TI   = 3'd0;
  localparam logic [2:0]  W_SRC  = 3'd1;
  localparam logic [2:0]  W_DST  = 3'd2;
  localparam logic [2:0]  W_LEN  = 3'd3;
  localparam logic [2:0]  W_NXT  = 3'd5;
  localparam logic [2:0]  W_LAST = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic inten;
    logic dinc;
    logic dpace;
    logic sinc;
    logic space;
  } xfer_flags_t;

endpackage

// File: rtl/dma_chain_pace.sv
module dma_chain_pace #(
  parameter int NUM_DREQ = 8,
  parameter int PSEL_W   = 3
) (
  input  logic [NUM_DREQ-1:0] dreq_i,
  input  logic [PSEL_W-1:0]   sel_i,
  output logic                hit_o
);

  localparam int SPAN = 1 << PSEL_W;

  logic [SPAN-1:0] lines;

  generate
    if (SPAN == NUM_DREQ) begin : g_exact
      assign lines = dreq_i;
    end else begin : g_padded
      assign lines = {{(SPAN - NUM_DREQ){1'b0}}, dreq_i};
    end
  endgenerate

  assign hit_o = lines[sel_i];

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_DREQ = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst_i,
  input  logic              active_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] cba_i,
  input  logic [NUM_DREQ-1:0] dreq_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [31:0]       mem_rdata_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [ADDR_W-1:0] nxt_o,
  output logic              held_o,
  output logic              blk_done_o,
  output logic              blk_int_o,
  output logic              chain_end_o,
  output logic              fault_o
);

  localparam int PSEL_W = (NUM_DREQ > 1) ? $clog2(NUM_DREQ) : 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  seq_state_e        state_q, state_d;
  logic              req_q, req_d;
  logic [FIDX_W-1:0] fidx_q, fidx_d;
  logic [ADDR_W-1:0] fptr_q, fptr_d;
  xfer_flags_t       flags_q, flags_d;
  logic [PSEL_W-1:0] psel_q, psel_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [31:0]       len_q, len_d;
  logic [ADDR_W-1:0] nxt_q, nxt_d;
  logic [31:0]       data_q, data_d;

  logic dreq_hit;
  logic pace_ok;
  logic resp;
  logic fault;

  dma_chain_pace #(
    .NUM_DREQ (NUM_DREQ),
    .PSEL_W   (PSEL_W)
  ) u_pace (
    .dreq_i (dreq_i),
    .sel_i  (psel_q),
    .hit_o  (dreq_hit)
  );

  assign pace_ok = (state_q == ST_WRITE) ? (!flags_q.dpace || dreq_hit)
                                         : (!flags_q.space || dreq_hit);
  assign resp    = req_q && mem_ack_i;
  assign fault   = resp && mem_err_i;

  // Next-state process
  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    fidx_d  = fidx_q;
    fptr_d  = fptr_q;
    flags_d = flags_q;
    psel_d  = psel_q;
    src_d   = src_q;
    dst_d   = dst_q;
    len_d   = len_q;
    nxt_d   = nxt_q;
    data_d  = data_q;

    unique case (state_q)
      ST_IDLE: begin
        if (active_i) begin
          state_d = ST_FETCH;
          fidx_d  = '0;
          fptr_d  = cba_i;
        end
      end
      ST_FETCH: begin
        if (!req_q) begin
          req_d = active_i;
        end else if (mem_ack_i) begin
          req_d  = 1'b0;
          fptr_d = fptr_q + STEP;
          fidx_d = fidx_q + 1'b1;
          if (!mem_err_i) begin
            unique case (fidx_q)
              W_TI: begin
                flags_d.inten = mem_rdata_i[TI_INTEN];
                flags_d.dinc  = mem_rdata_i[TI_DINC];
                flags_d.dpace = mem_rdata_i[TI_DPACE];
                flags_d.sinc  = mem_rdata_i[TI_SINC];
                flags_d.space = mem_rdata_i[TI_SPACE];
                psel_d        = mem_rdata_i[TI_PSEL +: PSEL_W];
              end
              W_SRC: src_d = mem_rdata_i[ADDR_W-1:0];
              W_DST: dst_d = mem_rdata_i[ADDR_W-1:0];
              W_LEN: len_d = mem_rdata_i;
              W_NXT: nxt_d = mem_rdata_i[ADDR_W-1:0];
              default: ;
            endcase
          end
          if (fidx_q == W_LAST) begin
            state_d = (len_q == 32'd0) ? ST_DONE : ST_READ;
          end
        end
      end
      ST_READ: begin
        if (!req_q) begin
          if (active_i && abort_i)       state_d = ST_DONE;
          else if (active_i && pace_ok)  req_d   = 1'b1;
        end else if (mem_ack_i) begin
          req_d   = 1'b0;
          data_d  = mem_rdata_i;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (!req_q) begin
          if (active_i && abort_i)       state_d = ST_DONE;
          else if (active_i && pace_ok)  req_d   = 1'b1;
        end else if (mem_ack_i) begin
          req_d = 1'b0;
          len_d = len_q - 32'd4;
          if (flags_q.sinc) src_d = src_q + STEP;
          if (flags_q.dinc) dst_d = dst_q + STEP;
          state_d = (len_q <= 32'd4) ? ST_DONE : ST_READ;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase

    if (fault) begin
      state_d = ST_IDLE;
      req_d   = 1'b0;
      len_d   = len_q;
      src_d   = src_q;
      dst_d   = dst_q;
    end

    if (srst_i) begin
      state_d = ST_IDLE;
      req_d   = 1'b0;
      fidx_d  = '0;
      fptr_d  = '0;
      flags_d = '0;
      psel_d  = '0;
      src_d   = '0;
      dst_d   = '0;
      len_d   = '0;
      nxt_d   = '0;
      data_d  = '0;
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      fidx_q  <= '0;
      fptr_q  <= '0;
      flags_q <= '0;
      psel_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      nxt_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      fidx_q  <= fidx_d;
      fptr_q  <= fptr_d;
      flags_q <= flags_d;
      psel_q  <= psel_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      len_q   <= len_d;
      nxt_q   <= nxt_d;
      data_q  <= data_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_FETCH: mem_addr_o = fptr_q;
      ST_READ:  mem_addr_o = src_q;
      ST_WRITE: mem_addr_o = dst_q;
      default:  mem_addr_o = '0;
    endcase
  end

  assign mem_req_o   = req_q;
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_wdata_o = data_q;
  assign src_o       = src_q;
  assign dst_o       = dst_q;
  assign nxt_o       = nxt_q;
  assign held_o      = active_i && !abort_i && !req_q && !pace_ok &&
                       ((state_q == ST_READ) || (state_q == ST_WRITE));
  assign blk_done_o  = (state_q == ST_DONE);
  assign blk_int_o   = flags_q.inten && !abort_i;
  assign chain_end_o = (nxt_q == '0);
  assign fault_o     = fault;

  // R7: no request starts while the channel is paused
  a_r7_no_issue_paused: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && !active_i) |=> !req_q);

  // R11: a pending request keeps address and direction until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !mem_ack_i && !srst_i) |=> (req_q && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R6: a paced read waits for its selected request line
  a_r6_pace_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && flags_q.space && !dreq_hit && !req_q) |=> !req_q);

  // R3: a destination without increment keeps its address after each word
  a_r3_fixed_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE && resp && !mem_err_i && !flags_q.dinc && !srst_i)
      |=> (dst_q == $past(dst_q)));

endmodule

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              blk_done_i,
  input  logic              blk_int_i,
  input  logic              chain_end_i,
  input  logic              fault_i,
  input  logic              held_i,
  input  logic [ADDR_W-1:0] nxt_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  output logic              srst_o,
  output logic              active_o,
  output logic              abort_o,
  output logic [ADDR_W-1:0] cba_o,
  output logic              irq_o
);

  logic              active_q, active_d;
  logic              int_q, int_d;
  logic              err_q, err_d;
  logic              abort_q, abort_d;
  logic [ADDR_W-1:0] cba_q, cba_d;

  logic cs_wr;
  logic cba_wr;

  assign cs_wr  = reg_we && (reg_addr == OFF_CS);
  assign cba_wr = reg_we && (reg_addr == OFF_CBA);
  assign srst_o = cs_wr && reg_wdata[CS_RESET];

  // Next-state process: sequencer events take priority over software writes
  always_comb begin
    active_d = active_q;
    int_d    = int_q;
    err_d    = err_q;
    abort_d  = abort_q;
    cba_d    = cba_q;

    if (cs_wr) begin
      active_d = reg_wdata[CS_ACTIVE];
      abort_d  = reg_wdata[CS_ABORT] && reg_wdata[CS_ACTIVE];
      if (reg_wdata[CS_INT]) int_d = 1'b0;
    end
    if (cba_wr) cba_d = reg_wdata[ADDR_W-1:0];

    if (blk_done_i) begin
      cba_d   = nxt_i;
      abort_d = 1'b0;
      if (chain_end_i) active_d = 1'b0;
      if (blk_int_i)   int_d    = 1'b1;
    end
    if (fault_i) begin
      err_d    = 1'b1;
      active_d = 1'b0;
    end

    if (srst_o) begin
      active_d = 1'b0;
      int_d    = 1'b0;
      err_d    = 1'b0;
      abort_d  = 1'b0;
      cba_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      int_q    <= 1'b0;
      err_q    <= 1'b0;
      abort_q  <= 1'b0;
      cba_q    <= '0;
    end else begin
      active_q <= active_d;
      int_q    <= int_d;
      err_q    <= err_d;
      abort_q  <= abort_d;
      cba_q    <= cba_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFF_CS: begin
        reg_rdata[CS_ACTIVE] = active_q;
        reg_rdata[CS_INT]    = int_q;
        reg_rdata[CS_PAUSED] = !active_q;
        reg_rdata[CS_HELD]   = held_i;
        reg_rdata[CS_ERR]    = err_q;
      end
      OFF_CBA: reg_rdata[ADDR_W-1:0] = cba_q;
      OFF_SRC: reg_rdata[ADDR_W-1:0] = src_i;
      OFF_DST: reg_rdata[ADDR_W-1:0] = dst_i;
      OFF_NXT: reg_rdata[ADDR_W-1:0] = nxt_i;
      default: ;
    endcase
  end

  assign active_o = active_q;
  assign abort_o  = abort_q;
  assign cba_o    = cba_q;
  assign irq_o    = int_q;

  // R4: completing the last block of a chain stops the channel
  a_r4_chain_end: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done_i && chain_end_i) |=> !active_q);

  // R5: an enabled block completion raises the interrupt
  a_r5_int_set: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done_i && blk_int_i && !srst_o) |=> int_q);

  // R9: an error response stops the channel and is recorded
  a_r9_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_i && !srst_o) |=> (!active_q && err_q));

  // R10: soft reset clears the register state at one edge
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    srst_o |=> (!active_q && !int_q && !err_q && !abort_q && cba_q == '0));

endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_DREQ = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [4:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic                mem_ack,
  input  logic                mem_err,
  input  logic [31:0]         mem_rdata,
  input  logic [NUM_DREQ-1:0] dreq,
  output logic                irq
);

  // Asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic              srst;
  logic              active;
  logic              abort;
  logic [ADDR_W-1:0] cba;
  logic [ADDR_W-1:0] src;
  logic [ADDR_W-1:0] dst;
  logic [ADDR_W-1:0] nxt;
  logic              held;
  logic              blk_done;
  logic              blk_int;
  logic              chain_end;
  logic              fault;

  dma_chain_regs #(
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .blk_done_i  (blk_done),
    .blk_int_i   (blk_int),
    .chain_end_i (chain_end),
    .fault_i     (fault),
    .held_i      (held),
    .nxt_i       (nxt),
    .src_i       (src),
    .dst_i       (dst),
    .srst_o      (srst),
    .active_o    (active),
    .abort_o     (abort),
    .cba_o       (cba),
    .irq_o       (irq)
  );

  dma_chain_seq #(
    .ADDR_W   (ADDR_W),
    .NUM_DREQ (NUM_DREQ)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .srst_i      (srst),
    .active_i    (active),
    .abort_i     (abort),
    .cba_i       (cba),
    .dreq_i      (dreq),
    .mem_req_o   (mem_req),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_ack_i   (mem_ack),
    .mem_err_i   (mem_err),
    .mem_rdata_i (mem_rdata),
    .src_o       (src),
    .dst_o       (dst),
    .nxt_o       (nxt),
    .held_o      (held),
    .blk_done_o  (blk_done),
    .blk_int_o   (blk_int),
    .chain_end_o (chain_end),
    .fault_o     (fault)
  );

endmodule

// File: tb/dma_chain_chan_test.sv
`timescale 1ns/1ps
module dma_chain_chan_test;

  localparam logic [31:0] F_INT = 32'h0000_0001;
  localparam logic [31:0] F_DI  = 32'h0000_0010;
  localparam logic [31:0] F_SI  = 32'h0000_0100;
  localparam logic [31:0] F_SP  = 32'h0000_0400;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic        mem_err;
  logic [31:0] mem_rdata;
  logic [7:0]  dreq;
  logic        irq;

  logic [31:0] mem [0:255];
  logic        err_en;
  logic [31:0] err_addr;

  int n_checks;
  int n_err;
  bit finished;

  dma_chain_chan uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .mem_rdata (mem_rdata),
    .dreq      (dreq),
    .irq       (irq)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // Memory model: acknowledges one cycle after a request is seen
  initial begin
    mem_ack   = 1'b0;
    mem_err   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
      end else if (mem_req && !mem_ack) begin
        mem_ack = 1'b1;
        mem_err = err_en && (mem_addr == err_addr);
        if (mem_we) begin
          if (!mem_err) mem[mem_addr[9:2]] = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[9:2]];
        end
      end else begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    bit done;
    done = 1'b0;
    for (int i = 0; i < 3000 && !done; i++) begin
      rd(5'h00, v);
      if (!v[0]) done = 1'b1;
    end
    chk(req, "channel went idle", {31'd0, done}, 32'd1);
  endtask

  task automatic put_cb(input int at, input logic [31:0] fl, input logic [31:0] s,
                        input logic [31:0] d, input logic [31:0] len, input logic [31:0] nx);
    mem[at/4 + 0] = fl;
    mem[at/4 + 1] = s;
    mem[at/4 + 2] = d;
    mem[at/4 + 3] = len;
    mem[at/4 + 4] = 32'h0000_0000;
    mem[at/4 + 5] = nx;
    mem[at/4 + 6] = 32'h0000_0000;
    mem[at/4 + 7] = 32'h0000_0000;
  endtask

  function automatic logic [31:0] srcw(input int i);
    return 32'hA500_0000 + 32'(i * 17);
  endfunction

  task automatic preset(input int at, input int n);
    for (int i = 0; i < n; i++) mem[at/4 + i] = 32'hDEAD_0000 | 32'(i);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(5'h00, v); chk("R1", "status after reset", v, 32'h0000_0010);
    rd(5'h04, v); chk("R1", "block pointer", v, 32'h0);
    rd(5'h0C, v); chk("R1", "live source", v, 32'h0);
    rd(5'h10, v); chk("R1", "live destination", v, 32'h0);
    rd(5'h1C, v); chk("R1", "link", v, 32'h0);
    chk("R1", "irq", {31'd0, irq}, 32'd0);
    chk("R1", "mem_req", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    preset(32'h200, 8);
    put_cb(32'h000, F_SI | F_DI | F_INT, 32'h100, 32'h200, 32'd16, 32'h0);
    wr(5'h04, 32'h000);
    wr(5'h00, 32'h1);
    wait_idle("R2");
    for (int i = 0; i < 4; i++) chk("R2", "copied word", mem[128 + i], srcw(i));
    chk("R2", "word past end untouched", mem[132], 32'hDEAD_0004);
    rd(5'h0C, v); chk("R3", "source advanced", v, 32'h110);
    rd(5'h10, v); chk("R3", "destination advanced", v, 32'h210);
    rd(5'h04, v); chk("R4", "pointer took zero link", v, 32'h0);
    rd(5'h00, v); chk("R5", "interrupt flag set", v & 32'h4, 32'h4);
    chk("R5", "irq high", {31'd0, irq}, 32'd1);
    wr(5'h00, 32'h4);
    @(negedge clk);
    chk("R5", "irq cleared by write-one", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_fixed_dst;
    logic [31:0] v;
    preset(32'h300, 4);
    put_cb(32'h060, F_SI, 32'h100, 32'h300, 32'd16, 32'h0);
    wr(5'h04, 32'h060);
    wr(5'h00, 32'h1);
    wait_idle("R3");
    chk("R3", "fixed destination holds last word", mem[192], srcw(3));
    chk("R3", "next word not touched", mem[193], 32'hDEAD_0001);
    rd(5'h10, v); chk("R3", "destination register fixed", v, 32'h300);
    chk("R5", "no irq without enable", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_zero_len;
    preset(32'h200, 2);
    put_cb(32'h060, F_SI | F_DI | F_INT, 32'h100, 32'h200, 32'd0, 32'h0);
    wr(5'h04, 32'h060);
    wr(5'h00, 32'h1);
    wait_idle("R2");
    chk("R2", "zero length moves nothing", mem[128], 32'hDEAD_0000);
    chk("R5", "zero length block interrupts", {31'd0, irq}, 32'd1);
    wr(5'h00, 32'h4);
  endtask

  task automatic t_chain_ignored;
    logic [31:0] v;
    preset(32'h200, 4);
    preset(32'h280, 4);
    put_cb(32'h020, F_SI | F_DI, 32'h100, 32'h200, 32'd8, 32'h040);
    put_cb(32'h040, F_SI | F_DI, 32'h108, 32'h280, 32'd8, 32'h0);
    wr(5'h04, 32'h020);
    wr(5'h00, 32'h1);
    wait_idle("R4");
    chk("R4", "first block word0", mem[128], srcw(0));
    chk("R4", "first block word1", mem[129], srcw(1));
    chk("R4", "first block stops", mem[130], 32'hDEAD_0002);
    chk("R4", "second block word0", mem[160], srcw(2));
    chk("R4", "second block word1", mem[161], srcw(3));
    rd(5'h04, v); chk("R4", "pointer ends at zero", v, 32'h0);
    wr(5'h0C, 32'hFFFF_FFF0);
    wr(5'h10, 32'hFFFF_FFF0);
    wr(5'h1C, 32'hFFFF_FFF0);
    rd(5'h0C, v); chk("R11", "source write ignored", v, 32'h110);
    rd(5'h10, v); chk("R11", "destination write ignored", v, 32'h288);
    rd(5'h1C, v); chk("R11", "link write ignored", v, 32'h0);
  endtask

  task automatic t_pace;
    logic [31:0] v;
    preset(32'h200, 4);
    put_cb(32'h000, F_SI | F_DI | F_SP | (32'd3 << 16), 32'h100, 32'h200, 32'd8, 32'h0);
    dreq = 8'h00;
    wr(5'h04, 32'h000);
    wr(5'h00, 32'h1);
    repeat (40) @(negedge clk);
    rd(5'h00, v); chk("R6", "held flag while waiting", v & 32'h21, 32'h21);
    chk("R6", "nothing written while held", mem[128], 32'hDEAD_0000);
    dreq = 8'h04;
    repeat (20) @(negedge clk);
    rd(5'h00, v); chk("R6", "other line does not release", v & 32'h20, 32'h20);
    chk("R6", "still nothing written", mem[128], 32'hDEAD_0000);
    dreq = 8'h08;
    wait_idle("R6");
    chk("R6", "paced word0", mem[128], srcw(0));
    chk("R6", "paced word1", mem[129], srcw(1));
    dreq = 8'h00;
  endtask

  task automatic t_pause;
    logic [31:0] v, s0;
    int reqs;
    preset(32'h200, 16);
    put_cb(32'h000, F_SI | F_DI, 32'h100, 32'h200, 32'd64, 32'h0);
    wr(5'h04, 32'h000);
    wr(5'h00, 32'h1);
    repeat (30) @(negedge clk);
    wr(5'h00, 32'h0);
    repeat (4) @(negedge clk);
    rd(5'h0C, s0);
    reqs = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (mem_req) reqs++;
    end
    chk("R7", "no requests while paused", 32'(reqs), 32'd0);
    rd(5'h0C, v); chk("R7", "source frozen", v, s0);
    rd(5'h00, v); chk("R7", "paused flag", v & 32'h11, 32'h10);
    chk("R7", "copy stopped mid block", mem[143], 32'hDEAD_000F);
    wr(5'h00, 32'h1);
    wait_idle("R7");
    for (int i = 0; i < 16; i++) chk("R7", "resumed copy word", mem[128 + i], srcw(i));
  endtask

  task automatic t_abort;
    logic [31:0] v;
    preset(32'h200, 2);
    preset(32'h280, 2);
    put_cb(32'h000, F_SI | F_DI | F_SP | F_INT | (32'd1 << 16), 32'h100, 32'h200, 32'd8, 32'h020);
    put_cb(32'h020, F_SI | F_DI, 32'h100, 32'h280, 32'd8, 32'h0);
    dreq = 8'h00;
    wr(5'h04, 32'h000);
    wr(5'h00, 32'h1);
    repeat (30) @(negedge clk);
    wr(5'h00, 32'h4000_0001);
    wait_idle("R8");
    chk("R8", "aborted block wrote nothing", mem[128], 32'hDEAD_0000);
    chk("R8", "next block word0", mem[160], srcw(0));
    chk("R8", "next block word1", mem[161], srcw(1));
    chk("R8", "aborted block no irq", {31'd0, irq}, 32'd0);
    rd(5'h04, v); chk("R8", "pointer followed link chain", v, 32'h0);
  endtask

  task automatic t_error;
    logic [31:0] v;
    preset(32'h200, 4);
    put_cb(32'h000, F_SI | F_DI, 32'h100, 32'h200, 32'd16, 32'h0);
    err_en   = 1'b1;
    err_addr = 32'h104;
    wr(5'h04, 32'h000);
    wr(5'h00, 32'h1);
    wait_idle("R9");
    rd(5'h00, v); chk("R9", "error flag, inactive", v & 32'h101, 32'h100);
    chk("R9", "word before error copied", mem[128], srcw(0));
    chk("R9", "no write after error", mem[129], 32'hDEAD_0001);
    chk("R9", "no request after error", {31'd0, mem_req}, 32'd0);
    err_en = 1'b0;
  endtask

  task automatic t_soft_reset;
    logic [31:0] v;
    put_cb(32'h000, F_SI | F_DI | F_SP, 32'h100, 32'h200, 32'd8, 32'h020);
    dreq = 8'h00;
    wr(5'h04, 32'h000);
    wr(5'h00, 32'h1);
    repeat (30) @(negedge clk);
    wr(5'h00, 32'h8000_0000);
    rd(5'h00, v); chk("R10", "status back to reset", v, 32'h0000_0010);
    rd(5'h04, v); chk("R10", "pointer cleared", v, 32'h0);
    rd(5'h0C, v); chk("R10", "source cleared", v, 32'h0);
    rd(5'h1C, v); chk("R10", "link cleared", v, 32'h0);
    chk("R10", "request dropped", {31'd0, mem_req}, 32'd0);
  endtask

  initial begin
    n_checks  = 0;
    n_err     = 0;
    finished  = 1'b0;
    rst_n     = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    dreq      = '0;
    err_en    = 1'b0;
    err_addr  = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) mem[64 + i] = srcw(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    t_reset();
    t_basic();
    t_fixed_dst();
    t_zero_len();
    t_chain_ignored();
    t_pace();
    t_pause();
    t_abort();
    t_error();
    t_soft_reset();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule